// File: doc/BRIEF.md
# Mixed-Reliability Cache Set Controller

This block runs one set of an eight-way set-associative cache in which two ways are built from large, robust cells and six from small cells that may flip bits at low supply voltage. All eight ways take part in lookup at low voltage. The block accepts one request at a time (a read or a write, a tag and a full-line write data word) and answers with hit or miss and the line data. It talks to the next memory level through a posted writeback port and a fill request/response port.

Placement follows the dirty state of a line. A modified line lives only in a robust way, while a clean line lives only in a non-robust way, so a bit error in a non-robust way can always be repaired by refetching. A write that hits a non-robust way breaks that rule, and a static policy input picks the repair. Writeback pushes the new data down at once so the line stays clean. Swap moves the line into the least recently used robust way and moves the displaced robust line into the freed non-robust slot. Duplicate copies the line into the partner way of a fixed pair. The robust group and the non-robust group each keep their own recency order.

Top module: `mrc_set_ctrl`

## Requirements
- R1: After reset the block is idle (busy low, no response) and every way is invalid, so the first access to any tag misses.
- R2: A read miss issues exactly one fill request carrying the request tag, installs the returned data clean in the least recently used non-robust way, and answers miss with the fill data.
- R3: A write miss issues no fill request, installs the write data as a dirty line in the least recently used robust way, and answers miss one cycle after acceptance.
- R4: An evicted line is written back only when dirty: a dirty robust victim gives one writeback, a clean non-robust victim gives none, and a dirty duplicated non-robust victim gives one writeback and leaves its copy clean.
- R5: A read hit answers hit with the stored data one cycle after acceptance and causes no memory traffic.
- R6: A write hit in a robust way updates the line and causes no memory traffic.
- R7: With policy code 0 (writeback), a write hit in a non-robust way stores the data, issues one writeback of the new data, and the line stays resident and clean.
- R8: With policy code 1 (swap), a write hit in a non-robust way places the new data dirty in the least recently used robust way, moves the old robust line clean into the freed non-robust way after writing it back if dirty, keeps both lines resident, and answers two cycles after acceptance.
- R9: With policy code 2 (duplicate), non-robust ways are paired as (0,1), (2,3), (4,5); a write hit copies the new line into the partner way, replacing its old line, issues no writeback, and answers two cycles after acceptance.
- R10: The robust and non-robust groups keep independent recency orders; a hit or fill changes only its own group's order, and after reset the highest-numbered way of each group is the first victim.
- R11: Busy is high from the cycle after acceptance until the response cycle, and each accepted request produces exactly one response.
- R12: Every read returns the most recently written value of its tag, whether it hits or is refilled from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_policy | input | 2 | Non-robust write-hit policy: 0 writeback, 1 swap, 2 duplicate; static |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_tag | input | TAG_W | Request tag |
| req_wdata | input | DATA_W | Write data (whole line) |
| busy | output | 1 | Controller is handling a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request hit in the set |
| resp_rdata | output | DATA_W | Line data (write data for writes) |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_tag | output | TAG_W | Tag of the line written back |
| wb_data | output | DATA_W | Data of the line written back |
| fill_req | output | 1 | One-cycle fill request strobe |
| fill_tag | output | TAG_W | Tag to fetch |
| fill_valid | input | 1 | Fill data strobe |
| fill_data | input | DATA_W | Fill data |

## Verification
The bench aims at the hand-offs between groups: a dirty robust line pushed out by a write miss, which a design without writeback would lose so a later read would return stale memory data; a swap whose displaced robust line is dirty, which a wrong design would drop or leave dirty in a non-robust way; and a duplicated pair, where a design that skipped the copy would keep the partner's old line hitting, and one that wrote back both copies or neither would show the wrong writeback count. Recency is probed by predicting exactly which line each fill evicts, so a design that shared one order across groups, or touched the wrong group on a robust access, evicts the wrong line and turns an expected hit into a miss. Latency of one or two cycles is measured per response to catch a busy window that is too short or too long.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   typedef enum logic [1:0] {
      POL_WRITEBACK = 2'd0,
      POL_SWAP      = 2'd1,
      POL_DUPLICATE = 2'd2
   } wpol_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_SWAP,
      ST_DUP,
      ST_FILL
   } cstate_e;
endpackage

// File: rtl/mrc_age_lru.sv
module mrc_age_lru #(
   parameter int N = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 touch,
   input  logic [$clog2(N)-1:0] touch_idx,
   output logic [$clog2(N)-1:0] victim_idx
);
   localparam int IW = $clog2(N);
   localparam logic [IW-1:0] OLDEST = IW'(N - 1);

   generate
      if (N < 2) begin : g_bad_n
         $error("mrc_age_lru needs at least two ways");
      end
   endgenerate

   logic [IW-1:0] age [N];
   logic [N-1:0]  is_old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age[i] <= IW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)
               age[i] <= '0;
            else if (age[i] < age[touch_idx])
               age[i] <= age[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         is_old[i] = (age[i] == OLDEST);
         if (is_old[i]) victim_idx = IW'(i);
      end
   end

   // R10: ages stay a permutation, so exactly one way is oldest
   a_r10_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_old) == 1);
endmodule

// File: rtl/mrc_tag_match.sv
module mrc_tag_match #(
   parameter int N     = 6,
   parameter int TAG_W = 16
) (
   input  logic [N-1:0]            vld,
   input  logic [N-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]        key,
   output logic                    hit,
   output logic [$clog2(N)-1:0]    hit_idx
);
   localparam int IW = $clog2(N);
   logic [N-1:0] match;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_cmp
         assign match[g] = vld[g] && (tags[g] == key);
      end
   endgenerate

   // lowest matching way wins
   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (match[i]) hit_idx = IW'(i);
   end
   assign hit = |match;
endmodule

// File: rtl/mrc_set_ctrl.sv
module mrc_set_ctrl
   import mrc_pkg::*;
#(
   parameter int TAG_W    = 16,
   parameter int DATA_W   = 32,
   parameter int ROB_WAYS = 2,
   parameter int NR_WAYS  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        wr_policy,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              wb_valid,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [DATA_W-1:0] wb_data,
   output logic              fill_req,
   output logic [TAG_W-1:0]  fill_tag,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int RIW = $clog2(ROB_WAYS);
   localparam int NIW = $clog2(NR_WAYS);
   localparam logic [NIW-1:0] PAIR_BIT = NIW'(1);

   generate
      if (ROB_WAYS < 2 || NR_WAYS < 2) begin : g_bad_ways
         $error("mrc_set_ctrl needs at least two ways per group");
      end
      if (NR_WAYS % 2 != 0) begin : g_bad_pairs
         $error("mrc_set_ctrl needs an even non-robust way count for pairing");
      end
      if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("mrc_set_ctrl widths must be positive");
      end
   endgenerate

   // way storage, one array per cell group
   logic [ROB_WAYS-1:0]             r_vld, r_dty;
   logic [ROB_WAYS-1:0][TAG_W-1:0]  r_tag;
   logic [ROB_WAYS-1:0][DATA_W-1:0] r_dat;
   logic [NR_WAYS-1:0]              n_vld, n_dty;
   logic [NR_WAYS-1:0][TAG_W-1:0]   n_tag;
   logic [NR_WAYS-1:0][DATA_W-1:0]  n_dat;

   cstate_e           state;
   wpol_e             pol;
   logic              q_write;
   logic [TAG_W-1:0]  q_tag;
   logic [DATA_W-1:0] q_data;
   logic [NIW-1:0]    h_q;
   logic [NIW-1:0]    nv_q;

   logic           r_hit, n_hit;
   logic [RIW-1:0] r_hidx, r_vic, r_tidx;
   logic [NIW-1:0] n_hidx, n_vic, n_tidx, n_vic_mate, h_mate;
   logic           r_touch, n_touch;

   assign pol        = wpol_e'(wr_policy);
   assign busy       = (state != ST_IDLE);
   assign n_vic_mate = n_vic ^ PAIR_BIT;
   assign h_mate     = h_q ^ PAIR_BIT;

   mrc_tag_match #(.N(ROB_WAYS), .TAG_W(TAG_W)) i_rob_match (
      .vld(r_vld), .tags(r_tag), .key(q_tag), .hit(r_hit), .hit_idx(r_hidx));

   mrc_tag_match #(.N(NR_WAYS), .TAG_W(TAG_W)) i_nr_match (
      .vld(n_vld), .tags(n_tag), .key(q_tag), .hit(n_hit), .hit_idx(n_hidx));

   mrc_age_lru #(.N(ROB_WAYS)) i_rob_lru (
      .clk(clk), .rst_n(rst_n), .touch(r_touch), .touch_idx(r_tidx),
      .victim_idx(r_vic));

   mrc_age_lru #(.N(NR_WAYS)) i_nr_lru (
      .clk(clk), .rst_n(rst_n), .touch(n_touch), .touch_idx(n_tidx),
      .victim_idx(n_vic));

   // recency updates: only the group that is touched moves
   always_comb begin
      r_touch = 1'b0;
      r_tidx  = r_hidx;
      n_touch = 1'b0;
      n_tidx  = n_hidx;
      unique case (state)
         ST_LOOK: begin
            if (r_hit) begin
               r_touch = 1'b1;
            end else if (n_hit) begin
               n_touch = 1'b1;
            end else if (q_write) begin
               r_touch = 1'b1;
               r_tidx  = r_vic;
            end
         end
         ST_SWAP: begin
            r_touch = 1'b1;
            r_tidx  = r_vic;
            n_touch = 1'b1;
            n_tidx  = h_q;
         end
         ST_FILL: begin
            n_touch = fill_valid;
            n_tidx  = nv_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         r_vld      <= '0;
         r_dty      <= '0;
         r_tag      <= '0;
         r_dat      <= '0;
         n_vld      <= '0;
         n_dty      <= '0;
         n_tag      <= '0;
         n_dat      <= '0;
         q_write    <= 1'b0;
         q_tag      <= '0;
         q_data     <= '0;
         h_q        <= '0;
         nv_q       <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_rdata <= '0;
         wb_valid   <= 1'b0;
         wb_tag     <= '0;
         wb_data    <= '0;
         fill_req   <= 1'b0;
         fill_tag   <= '0;
      end else begin
         resp_valid <= 1'b0;
         wb_valid   <= 1'b0;
         fill_req   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  q_write <= req_write;
                  q_tag   <= req_tag;
                  q_data  <= req_wdata;
                  state   <= ST_LOOK;
               end
            end

            ST_LOOK: begin
               if (r_hit) begin
                  if (q_write) begin
                     r_dat[r_hidx] <= q_data;
                     r_dty[r_hidx] <= 1'b1;
                  end
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b1;
                  resp_rdata <= q_write ? q_data : r_dat[r_hidx];
                  state      <= ST_IDLE;
               end else if (n_hit) begin
                  h_q <= n_hidx;
                  if (!q_write) begin
                     resp_valid <= 1'b1;
                     resp_hit   <= 1'b1;
                     resp_rdata <= n_dat[n_hidx];
                     state      <= ST_IDLE;
                  end else begin
                     unique case (pol)
                        POL_SWAP: state <= ST_SWAP;
                        POL_DUPLICATE: begin
                           n_dat[n_hidx] <= q_data;
                           n_dty[n_hidx] <= 1'b1;
                           state         <= ST_DUP;
                        end
                        default: begin
                           n_dat[n_hidx] <= q_data;
                           n_dty[n_hidx] <= 1'b0;
                           wb_valid      <= 1'b1;
                           wb_tag        <= q_tag;
                           wb_data       <= q_data;
                           resp_valid    <= 1'b1;
                           resp_hit      <= 1'b1;
                           resp_rdata    <= q_data;
                           state         <= ST_IDLE;
                        end
                     endcase
                  end
               end else if (q_write) begin
                  if (r_vld[r_vic] && r_dty[r_vic]) begin
                     wb_valid <= 1'b1;
                     wb_tag   <= r_tag[r_vic];
                     wb_data  <= r_dat[r_vic];
                  end
                  r_vld[r_vic] <= 1'b1;
                  r_dty[r_vic] <= 1'b1;
                  r_tag[r_vic] <= q_tag;
                  r_dat[r_vic] <= q_data;
                  resp_valid   <= 1'b1;
                  resp_hit     <= 1'b0;
                  resp_rdata   <= q_data;
                  state        <= ST_IDLE;
               end else begin
                  if (n_vld[n_vic] && n_dty[n_vic]) begin
                     wb_valid <= 1'b1;
                     wb_tag   <= n_tag[n_vic];
                     wb_data  <= n_dat[n_vic];
                     if (n_vld[n_vic_mate] && n_tag[n_vic_mate] == n_tag[n_vic])
                        n_dty[n_vic_mate] <= 1'b0;
                  end
                  n_vld[n_vic] <= 1'b0;
                  n_dty[n_vic] <= 1'b0;
                  nv_q         <= n_vic;
                  fill_req     <= 1'b1;
                  fill_tag     <= q_tag;
                  state        <= ST_FILL;
               end
            end

            ST_SWAP: begin
               if (r_vld[r_vic] && r_dty[r_vic]) begin
                  wb_valid <= 1'b1;
                  wb_tag   <= r_tag[r_vic];
                  wb_data  <= r_dat[r_vic];
               end
               n_vld[h_q]   <= r_vld[r_vic];
               n_dty[h_q]   <= 1'b0;
               n_tag[h_q]   <= r_tag[r_vic];
               n_dat[h_q]   <= r_dat[r_vic];
               r_vld[r_vic] <= 1'b1;
               r_dty[r_vic] <= 1'b1;
               r_tag[r_vic] <= q_tag;
               r_dat[r_vic] <= q_data;
               resp_valid   <= 1'b1;
               resp_hit     <= 1'b1;
               resp_rdata   <= q_data;
               state        <= ST_IDLE;
            end

            ST_DUP: begin
               n_vld[h_mate] <= 1'b1;
               n_dty[h_mate] <= 1'b1;
               n_tag[h_mate] <= q_tag;
               n_dat[h_mate] <= q_data;
               resp_valid    <= 1'b1;
               resp_hit      <= 1'b1;
               resp_rdata    <= q_data;
               state         <= ST_IDLE;
            end

            ST_FILL: begin
               if (fill_valid) begin
                  n_vld[nv_q] <= 1'b1;
                  n_dty[nv_q] <= 1'b0;
                  n_tag[nv_q] <= q_tag;
                  n_dat[nv_q] <= fill_data;
                  resp_valid  <= 1'b1;
                  resp_hit    <= 1'b0;
                  resp_rdata  <= fill_data;
                  state       <= ST_IDLE;
               end
            end

            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11: a response always coincides with the controller going free
   a_r11_resp_frees: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !busy);

   // R3: fills are only requested for reads
   a_r3_no_fill_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> !q_write);

   // R2: a fill request is a single-cycle pulse
   a_r2_fill_single: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> !fill_req);

   // R7: outside duplicate policy no non-robust way ever holds dirty data
   a_r7_nr_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (pol != POL_DUPLICATE) |-> (n_dty == '0));

   // R9: a dirty non-robust line only exists while its pair holds the same tag
   a_r9_dirty_has_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && n_dty[0]) |-> (n_vld[1] && n_tag[1] == n_tag[0]));
endmodule

// File: tb/test_mrc_set_ctrl.sv
module test_mrc_set_ctrl;
   localparam int TW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    wr_policy = 2'd0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [TW-1:0] req_tag = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy, resp_valid, resp_hit;
   logic [DW-1:0] resp_rdata;
   logic          wb_valid;
   logic [TW-1:0] wb_tag;
   logic [DW-1:0] wb_data;
   logic          fill_req;
   logic [TW-1:0] fill_tag;
   logic          fill_valid = 1'b0;
   logic [DW-1:0] fill_data = '0;

   mrc_set_ctrl #(.TAG_W(TW), .DATA_W(DW), .ROB_WAYS(2), .NR_WAYS(6)) i_mrc_set_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_policy(wr_policy),
      .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
      .req_wdata(req_wdata), .busy(busy), .resp_valid(resp_valid),
      .resp_hit(resp_hit), .resp_rdata(resp_rdata), .wb_valid(wb_valid),
      .wb_tag(wb_tag), .wb_data(wb_data), .fill_req(fill_req),
      .fill_tag(fill_tag), .fill_valid(fill_valid), .fill_data(fill_data));

   always #10 clk = ~clk;

   typedef struct {
      bit          hit;
      logic [DW-1:0] data;
      int          lat;
      string       rq;
   } exp_t;

   exp_t          sbq[$];
   exp_t          e_cur;
   logic [DW-1:0] mem  [int];
   logic [DW-1:0] gold [int];
   int total = 0, bad = 0, nresp = 0, wb_cnt = 0, rd_cnt = 0, cyc = 0, acc = 0;
   bit done = 0;

   function automatic logic [DW-1:0] init_val(input logic [TW-1:0] t);
      return {t ^ 16'hC0DE, t};
   endfunction

   function automatic logic [DW-1:0] mem_get(input logic [TW-1:0] t);
      return mem.exists(int'(t)) ? mem[int'(t)] : init_val(t);
   endfunction

   function automatic logic [DW-1:0] gold_get(input logic [TW-1:0] t);
      return gold.exists(int'(t)) ? gold[int'(t)] : init_val(t);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // memory model: writebacks and fills
   always @(negedge clk) if (rst_n && wb_valid) begin
      mem[int'(wb_tag)] = wb_data;
      wb_cnt++;
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && fill_req) begin
            logic [TW-1:0] t;
            t = fill_tag;
            rd_cnt++;
            repeat (3) @(negedge clk);
            fill_data  = mem_get(t);
            fill_valid = 1'b1;
            @(negedge clk);
            fill_valid = 1'b0;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) if (rst_n && resp_valid) begin
      if (sbq.size() == 0) begin
         chk(1'b0, "R11", "response with no request", '0, '0);
      end else begin
         e_cur = sbq.pop_front();
         chk(resp_hit == e_cur.hit, e_cur.rq, "hit flag", DW'(resp_hit), DW'(e_cur.hit));
         chk(resp_rdata == e_cur.data, e_cur.rq, "data", resp_rdata, e_cur.data);
         if (e_cur.lat > 0)
            chk(cyc - acc == e_cur.lat, "R11", "latency", DW'(cyc - acc), DW'(e_cur.lat));
      end
      nresp++;
   end

   task automatic do_req(input bit w, input logic [TW-1:0] t, input logic [DW-1:0] d,
                         input bit exp_hit, input int lat, input string rq);
      exp_t e;
      int target;
      if (w) gold[int'(t)] = d;
      e.hit  = exp_hit;
      e.data = w ? d : gold_get(t);
      e.lat  = lat;
      e.rq   = rq;
      sbq.push_back(e);
      target = nresp + 1;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_tag   = t;
      req_wdata = d;
      @(posedge clk);
      #1 acc = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      while (nresp < target) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] pol);
      rst_n     = 1'b0;
      req_valid = 1'b0;
      wr_policy = pol;
      sbq.delete();
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", "busy in reset", DW'(busy), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && resp_valid == 1'b0, "R1", "idle after reset",
          DW'({busy, resp_valid}), '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int w0, r0;
      // ---------------- writeback policy ----------------
      do_reset(2'd0);
      r0 = rd_cnt;
      do_req(0, 16'h0011, '0, 0, 0, "R1");            // first access misses, fills NR5
      chk(rd_cnt - r0 == 1, "R2", "fill count", DW'(rd_cnt - r0), 1);
      w0 = wb_cnt; r0 = rd_cnt;
      do_req(0, 16'h0011, '0, 1, 1, "R5");
      chk(wb_cnt == w0 && rd_cnt == r0, "R5", "traffic on read hit", DW'(wb_cnt - w0), 0);
      r0 = rd_cnt;
      do_req(1, 16'h0012, 32'h1200_0001, 0, 1, "R3"); // robust way1
      do_req(1, 16'h0013, 32'h1300_0001, 0, 1, "R3"); // robust way0
      chk(rd_cnt == r0, "R3", "fill on write miss", DW'(rd_cnt - r0), 0);
      w0 = wb_cnt;
      do_req(1, 16'h0014, 32'h1400_0001, 0, 1, "R3"); // evicts dirty 0012
      chk(wb_cnt - w0 == 1, "R4", "dirty robust eviction writebacks", DW'(wb_cnt - w0), 1);
      chk(mem_get(16'h0012) == 32'h1200_0001, "R4", "written back data",
          mem_get(16'h0012), 32'h1200_0001);
      do_req(0, 16'h0012, '0, 0, 0, "R12");           // refetched into NR4
      w0 = wb_cnt;
      do_req(1, 16'h0011, 32'h1100_0002, 1, 1, "R7");
      chk(wb_cnt - w0 == 1, "R7", "writebacks on NR write hit", DW'(wb_cnt - w0), 1);
      chk(mem_get(16'h0011) == 32'h1100_0002, "R7", "pushed data",
          mem_get(16'h0011), 32'h1100_0002);
      do_req(0, 16'h0011, '0, 1, 1, "R7");
      w0 = wb_cnt;
      for (int i = 0; i < 5; i++)                    // fill NR3..NR0 then evict NR4
         do_req(0, 16'h0015 + 16'(i), '0, 0, 0, "R2");
      chk(wb_cnt == w0, "R4", "clean NR eviction writebacks", DW'(wb_cnt - w0), 0);
      do_req(0, 16'h0011, '0, 1, 1, "R10");           // NR order not disturbed by robust traffic
      do_req(0, 16'h0012, '0, 0, 0, "R4");            // evicted clean line misses
      w0 = wb_cnt;
      do_req(1, 16'h0013, 32'h1300_0002, 1, 1, "R6");
      chk(wb_cnt == w0, "R6", "traffic on robust write hit", DW'(wb_cnt - w0), 0);
      do_req(0, 16'h0013, '0, 1, 1, "R6");
      do_req(0, 16'h0011, '0, 1, 1, "R10");

      // ---------------- swap policy ----------------
      do_reset(2'd1);
      do_req(1, 16'h0021, 32'h2100_0001, 0, 1, "R3"); // way1
      do_req(1, 16'h0022, 32'h2200_0001, 0, 1, "R3"); // way0
      do_req(0, 16'h0023, '0, 0, 0, "R2");            // NR5
      w0 = wb_cnt;
      do_req(1, 16'h0023, 32'h2300_0002, 1, 2, "R8"); // swaps with 0021
      chk(wb_cnt - w0 == 1, "R8", "displaced line writebacks", DW'(wb_cnt - w0), 1);
      chk(mem_get(16'h0021) == 32'h2100_0001, "R8", "displaced data",
          mem_get(16'h0021), 32'h2100_0001);
      do_req(0, 16'h0021, '0, 1, 1, "R8");
      do_req(0, 16'h0023, '0, 1, 1, "R8");
      do_req(0, 16'h0022, '0, 1, 1, "R8");
      w0 = wb_cnt;
      do_req(1, 16'h0024, 32'h2400_0001, 0, 1, "R8"); // evicts dirty 0023 from robust
      chk(wb_cnt - w0 == 1, "R8", "swapped line dirty in robust", DW'(wb_cnt - w0), 1);
      chk(mem_get(16'h0023) == 32'h2300_0002, "R8", "swapped line data",
          mem_get(16'h0023), 32'h2300_0002);

      // ---------------- duplicate policy ----------------
      do_reset(2'd2);
      do_req(0, 16'h0031, '0, 0, 0, "R2");            // NR5
      do_req(0, 16'h0032, '0, 0, 0, "R2");            // NR4 (partner of NR5)
      w0 = wb_cnt;
      do_req(1, 16'h0031, 32'h3100_0002, 1, 2, "R9");
      chk(wb_cnt == w0, "R9", "writebacks on duplicate", DW'(wb_cnt - w0), 0);
      do_req(0, 16'h0032, '0, 0, 0, "R9");            // partner's old line gone
      do_req(0, 16'h0031, '0, 1, 1, "R9");
      w0 = wb_cnt;
      for (int i = 0; i < 6; i++)
         do_req(0, 16'h0040 + 16'(i), '0, 0, 0, "R2");
      chk(wb_cnt - w0 == 1, "R4", "duplicated pair writebacks", DW'(wb_cnt - w0), 1);
      chk(mem_get(16'h0031) == 32'h3100_0002, "R4", "duplicated data",
          mem_get(16'h0031), 32'h3100_0002);
      do_req(0, 16'h0031, '0, 0, 0, "R12");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule